// File: doc/BRIEF.md
# Duty-Cycled Address Gate with Word Budget

This block sits on the read-address and write-address channels between a manager and the memory side. It injects a controlled amount of interfering traffic behaviour by throttling address acceptance. Time is cut into an open window and a closed window, each with a programmed length in clock cycles. Addresses may pass only while the window is open. During the closed window every address waits.

Inside each open window, a shared word budget limits how much burst data can be admitted. Each accepted burst is charged its beat count as 64-bit words. A burst is let through only if it still fits under the cap. The budget is refilled whenever a new open window starts.

When both channels could go in the same cycle, one address is admitted per cycle, and the two channels take turns. Once a gated valid has been shown to the memory side, it stays up until the handshake completes, so the gate never withdraws an offered address.

Top module: `addr_pulse_gate`

## Requirements
- R1: After reset the gate is at the first cycle of an open window, the used budget is zero and the read channel has priority.
- R2: While the window is open, an address whose burst fits the budget is forwarded in the same cycle: the gated valid follows the incoming valid.
- R3: After `on_len` open cycles the window stays closed for `off_len` cycles. While it is closed, both gated valids and both gated readies are low, except for a grant held under R10.
- R4: With `off_len` equal to 0 the gate is always open. A new window, with a refilled budget, begins every `on_len` cycles, or every cycle when `on_len` is also 0.
- R5: With `on_len` equal to 0 and `off_len` nonzero, no address is ever forwarded.
- R6: A burst with length field L (number of beats minus one) costs L+1 words. It is charged at its handshake and is admitted only when the words already used plus L+1 do not exceed `word_cap`. An exact fit is admitted.
- R7: A `word_cap` of 0 removes the budget limit.
- R8: The used budget returns to zero at the start of every open window. A handshake in the last cycle before a new window does not carry into it.
- R9: At most one address is forwarded per cycle. When both channels are eligible, the channel that was not served by the most recent handshake wins. The read channel wins when nothing has been served since reset.
- R10: Once a gated valid is high without the matching ready, that channel stays granted until its handshake, regardless of window or budget.
- R11: For a granted channel, the gated valid equals its incoming valid and the gated ready equals its incoming ready. For a channel that is not granted, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_len | input | 16 | Open window length in cycles |
| off_len | input | 16 | Closed window length in cycles |
| word_cap | input | 16 | Words allowed per window, 0 = unlimited |
| ar_valid_i | input | 1 | Read address valid from manager |
| ar_len_i | input | 8 | Read burst length field (beats minus one) |
| ar_ready_o | output | 1 | Gated read address ready to manager |
| ar_valid_o | output | 1 | Gated read address valid to memory side |
| ar_ready_i | input | 1 | Read address ready from memory side |
| aw_valid_i | input | 1 | Write address valid from manager |
| aw_len_i | input | 8 | Write burst length field (beats minus one) |
| aw_ready_o | output | 1 | Gated write address ready to manager |
| aw_valid_o | output | 1 | Gated write address valid to memory side |
| aw_ready_i | input | 1 | Write address ready from memory side |

## Verification
A window counter that is off by one shows up at once as a gated valid during the first closed cycle, or as a missing one in the last open cycle. The bench sweeps every small on/off pair from a known reset, so the phase is fixed and such a slip appears within one period. A used-budget register that is not cleared, or that is charged the wrong amount, blocks or admits a burst in the next window. That change in the grant pattern is visible within a few cycles. A round-robin pointer or held grant in the wrong state is seen in the very cycle after a handshake or a stalled offer.

// File: rtl/apg_pkg.sv
package apg_pkg;
    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_RD   = 2'd1,
        LK_WR   = 2'd2
    } lock_e;

    typedef enum logic {
        PH_CLOSED = 1'b0,
        PH_OPEN   = 1'b1
    } phase_e;
endpackage

// File: rtl/apg_window.sv
module apg_window
    import apg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    output logic             gate_open,
    output logic             restart
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } win_t;

    win_t st_q, st_d;
    logic [CNT_W:0] cnt_inc;
    logic           last_open, last_closed, never_open;

    always_comb begin
        cnt_inc     = {1'b0, st_q.cnt} + 1'b1;
        last_open   = cnt_inc >= {1'b0, on_len};
        last_closed = cnt_inc >= {1'b0, off_len};
        never_open  = (on_len == '0) && (off_len != '0);
        st_d        = st_q;
        restart     = 1'b0;
        if (st_q.phase == PH_OPEN) begin
            if (last_open) begin
                st_d.cnt = '0;
                if (off_len == '0) begin
                    restart = 1'b1;
                end else begin
                    st_d.phase = PH_CLOSED;
                end
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end else begin
            if (last_closed) begin
                st_d.cnt   = '0;
                st_d.phase = PH_OPEN;
                restart    = 1'b1;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
        gate_open = (st_q.phase == PH_OPEN) && !never_open;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_OPEN, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // A closed window never lasts past its programmed length (R3)
    assert_closed_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CLOSED && last_closed) |=> (st_q.phase == PH_OPEN));
endmodule

// File: rtl/apg_budget.sv
module apg_budget #(
    parameter int LEN_W = 8,
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] cap,
    input  logic             restart,
    input  logic [LEN_W-1:0] len_r,
    input  logic [LEN_W-1:0] len_w,
    input  logic             hs_r,
    input  logic             hs_w,
    output logic             fit_r,
    output logic             fit_w
);
    localparam int USED_W = ((CAP_W > LEN_W) ? CAP_W : LEN_W) + 2;

    typedef struct packed {
        logic [USED_W-1:0] used;
    } bud_t;

    bud_t st_q, st_d;
    logic [USED_W-1:0] words_r, words_w, cap_x, charge;
    logic              unlimited;

    always_comb begin
        words_r   = USED_W'(len_r) + 1'b1;
        words_w   = USED_W'(len_w) + 1'b1;
        cap_x     = USED_W'(cap);
        unlimited = (cap == '0);
        fit_r     = unlimited || ((st_q.used + words_r) <= cap_x);
        fit_w     = unlimited || ((st_q.used + words_w) <= cap_x);
        charge    = '0;
        if (hs_r) charge = words_r;
        if (hs_w) charge = words_w;
        st_d = st_q;
        if (restart) begin
            st_d.used = '0;
        end else if (!unlimited) begin
            st_d.used = st_q.used + charge;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.used == '0));

    assert_within_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap != '0 && !restart && ((hs_r && fit_r) || (hs_w && fit_w)))
        |=> (st_q.used <= USED_W'($past(cap))));
endmodule

// File: rtl/apg_arbiter.sv
module apg_arbiter
    import apg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_open,
    input  logic vld_r,
    input  logic vld_w,
    input  logic rdy_r,
    input  logic rdy_w,
    input  logic fit_r,
    input  logic fit_w,
    output logic grant_r,
    output logic grant_w
);
    typedef struct packed {
        lock_e lock;
        logic  prefer_w;
    } arb_t;

    arb_t st_q, st_d;
    logic el_r, el_w;

    always_comb begin
        el_r    = vld_r && gate_open && fit_r;
        el_w    = vld_w && gate_open && fit_w;
        grant_r = 1'b0;
        grant_w = 1'b0;
        case (st_q.lock)
            LK_RD:   grant_r = 1'b1;
            LK_WR:   grant_w = 1'b1;
            default: begin
                if (el_r && el_w) begin
                    grant_r = !st_q.prefer_w;
                    grant_w = st_q.prefer_w;
                end else begin
                    grant_r = el_r;
                    grant_w = el_w;
                end
            end
        endcase
        st_d      = st_q;
        st_d.lock = LK_NONE;
        if (grant_r && vld_r && !rdy_r) st_d.lock = LK_RD;
        if (grant_w && vld_w && !rdy_w) st_d.lock = LK_WR;
        if (grant_r && vld_r && rdy_r)  st_d.prefer_w = 1'b1;
        if (grant_w && vld_w && rdy_w)  st_d.prefer_w = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lock: LK_NONE, prefer_w: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_r, grant_w}));
endmodule

// File: rtl/addr_pulse_gate.sv
module addr_pulse_gate #(
    parameter int CNT_W = 16,
    parameter int CAP_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    input  logic [CAP_W-1:0] word_cap,
    input  logic             ar_valid_i,
    input  logic [LEN_W-1:0] ar_len_i,
    output logic             ar_ready_o,
    output logic             ar_valid_o,
    input  logic             ar_ready_i,
    input  logic             aw_valid_i,
    input  logic [LEN_W-1:0] aw_len_i,
    output logic             aw_ready_o,
    output logic             aw_valid_o,
    input  logic             aw_ready_i
);
    logic gate_open, restart, fit_r, fit_w, grant_r, grant_w, hs_r, hs_w;

    apg_window #(.CNT_W(CNT_W)) u_window (
        .clk(clk), .rst_n(rst_n), .on_len(on_len), .off_len(off_len),
        .gate_open(gate_open), .restart(restart)
    );

    apg_budget #(.LEN_W(LEN_W), .CAP_W(CAP_W)) u_budget (
        .clk(clk), .rst_n(rst_n), .cap(word_cap), .restart(restart),
        .len_r(ar_len_i), .len_w(aw_len_i), .hs_r(hs_r), .hs_w(hs_w),
        .fit_r(fit_r), .fit_w(fit_w)
    );

    apg_arbiter u_arbiter (
        .clk(clk), .rst_n(rst_n), .gate_open(gate_open),
        .vld_r(ar_valid_i), .vld_w(aw_valid_i),
        .rdy_r(ar_ready_i), .rdy_w(aw_ready_i),
        .fit_r(fit_r), .fit_w(fit_w),
        .grant_r(grant_r), .grant_w(grant_w)
    );

    always_comb begin
        ar_valid_o = ar_valid_i && grant_r;
        ar_ready_o = ar_ready_i && grant_r;
        aw_valid_o = aw_valid_i && grant_w;
        aw_ready_o = aw_ready_i && grant_w;
        hs_r       = ar_valid_o && ar_ready_i;
        hs_w       = aw_valid_o && aw_ready_i;
    end

    assert_closed_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !$past(ar_valid_o && !ar_ready_i) && !$past(aw_valid_o && !aw_ready_i))
        |-> (!ar_valid_o && !aw_valid_o));

    assert_hold_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid_o && !ar_ready_i) |=> (!ar_valid_i || ar_valid_o));

    assert_hold_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid_o && !aw_ready_i) |=> (!aw_valid_i || aw_valid_o));
endmodule

// File: tb/addr_pulse_gate_bench.sv
module addr_pulse_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_CYC  = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] on_len = '0, off_len = '0, word_cap = '0;
    logic        ar_valid_i = 1'b0, ar_ready_i = 1'b0, aw_valid_i = 1'b0, aw_ready_i = 1'b0;
    logic [7:0]  ar_len_i = '0, aw_len_i = '0;
    logic        ar_ready_o, ar_valid_o, aw_ready_o, aw_valid_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_pulse_gate u_addr_pulse_gate (
        .clk(clk), .rst_n(rst_n), .on_len(on_len), .off_len(off_len),
        .word_cap(word_cap),
        .ar_valid_i(ar_valid_i), .ar_len_i(ar_len_i), .ar_ready_o(ar_ready_o),
        .ar_valid_o(ar_valid_o), .ar_ready_i(ar_ready_i),
        .aw_valid_i(aw_valid_i), .aw_len_i(aw_len_i), .aw_ready_o(aw_ready_o),
        .aw_valid_o(aw_valid_o), .aw_ready_i(aw_ready_i)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b (on=%0d off=%0d cap=%0d t=%0t)",
                     tag, act, exp, on_len, off_len, word_cap, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic do_reset(input int on, input int off, input int cap);
        rst_n = 1'b0;
        on_len = 16'(on); off_len = 16'(off); word_cap = 16'(cap);
        ar_valid_i = 1'b0; aw_valid_i = 1'b0; ar_ready_i = 1'b0; aw_ready_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Arithmetic model of the window, budget and turn-taking
    task automatic run_sweep(input int on, input int off, input int cap);
        int  used = 0;
        bit  pref_w = 1'b0;
        do_reset(on, off, cap);
        for (int k = 0; k < SWEEP_CYC; k++) begin
            bit vr, vw, open, fr, fw, er, ew, gr, gw, rs;
            int lr, lw;
            string tag;
            vr = (k % 5) != 4;
            vw = (k % 3) != 0;
            lr = k % 4;
            lw = (k * 3) % 5;
            ar_valid_i = vr; aw_valid_i = vw;
            ar_len_i = 8'(lr); aw_len_i = 8'(lw);
            ar_ready_i = 1'b1; aw_ready_i = 1'b1;
            #1;
            if (on == 0 && off != 0) open = 0;
            else if (off == 0)       open = 1;
            else                     open = (k % (on + off)) < on;
            fr = (cap == 0) || (used + lr + 1 <= cap);
            fw = (cap == 0) || (used + lw + 1 <= cap);
            er = vr && open && fr;
            ew = vw && open && fw;
            if (er && ew) begin gr = !pref_w; gw = pref_w; end
            else begin gr = er; gw = ew; end
            if (k == 0)                       tag = "R1";
            else if (!open)                   tag = (on == 0) ? "R5" : "R3";
            else if (er && ew)                tag = "R9";
            else if (off == 0)                tag = "R4";
            else if (cap == 0)                tag = "R7";
            else if (used == 0)               tag = "R8";
            else                              tag = "R6";
            chk(tag, ar_valid_o, gr);
            chk(tag, aw_valid_o, gw);
            chk("R11", ar_ready_o, gr);
            chk("R11", aw_ready_o, gw);
            if (gr) pref_w = 1'b1;
            if (gw) pref_w = 1'b0;
            if (off == 0)     rs = (on == 0) || ((k + 1) % on == 0);
            else if (on == 0) rs = 1'b0;
            else              rs = ((k + 1) % (on + off)) == 0;
            if (rs)              used = 0;
            else if (cap != 0)   used = used + (gr ? lr + 1 : 0) + (gw ? lw + 1 : 0);
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Held grant across a closed window: on=2 off=3, no cap
        do_reset(2, 3, 0);
        ar_valid_i = 1'b1; ar_len_i = 8'd0; ar_ready_i = 1'b0;
        #1;
        chk("R2", ar_valid_o, 1'b1);
        chk("R11", ar_ready_o, 1'b0);
        step();
        #1; chk("R10", ar_valid_o, 1'b1);
        step();
        #1; chk("R10", ar_valid_o, 1'b1);   // first closed cycle
        step();
        ar_ready_i = 1'b1;
        #1;
        chk("R10", ar_valid_o, 1'b1);
        chk("R11", ar_ready_o, 1'b1);
        step();
        aw_valid_i = 1'b1; aw_ready_i = 1'b1;
        #1;
        chk("R3", ar_valid_o, 1'b0);
        chk("R3", ar_ready_o, 1'b0);
        chk("R3", aw_valid_o, 1'b0);
        step();

        for (int on = 0; on < 4; on++) begin
            for (int off = 0; off < 4; off++) begin
                for (int ci = 0; ci < 3; ci++) begin
                    run_sweep(on, off, (ci == 0) ? 0 : ((ci == 1) ? 3 : 7));
                end
            end
        end
        finish_run();
    end
endmodule